// File: doc/BRIEF.md
# Colour Lookup Host Access Port

This block is the byte-wide host side of a colour lookup device. A host reaches everything through four offsets: two set a shared 12-bit address pointer, one is an indirect data port and one is a direct palette data port. Colours are stored as three bytes (red, green, blue). A 2-bit component index picks one of the three bytes, and most data accesses step that index. After the third component the pointer moves on to the next entry, so a host streams whole colours with repeated accesses to one offset.

The block holds the pointer, the index, a 528-entry palette array and a four-entry cursor-colour array. The indirect port is steered by the upper four pointer bits. Page 1 reaches the cursor colours inside the block. Pages 2 and 3 go out to attached register banks, which receive the strobe, the low pointer byte and the index. Those banks return read data and a request for how the pointer should move. Any other page reads zero and ignores writes.

Read data is registered and appears on the cycle after the read strobe.

Top module: `clut_host_port`

## Requirements
- R1: After reset the pointer, the component index, every palette byte, every cursor byte and `host_rdata` are zero.
- R2: `host_sel` 0 accesses the pointer low byte and `host_sel` 1 accesses the pointer high nibble. A write at select 0 replaces pointer bits 7:0 with `host_wdata`. A write at select 1 replaces pointer bits 11:8 with `host_wdata[3:0]`. A read at select 0 returns bits 7:0, and a read at select 1 returns bits 11:8 zero-extended. Any access at select 0 or 1 clears the component index.
- R3: A triplet advance moves the index 0 to 1 to 2. From 2 it returns the index to 0 and increments the pointer modulo 4096, so pointer 0xFFF becomes 0x000.
- R4: `host_sel` 3 accesses the palette. For pointer values below 528, it reads or writes byte `idx` (0 red, 1 green, 2 blue) of entry `ptr`. At pointer 528 (0x210) and above, writes are dropped and reads return 0.
- R5: Every palette access performs a triplet advance, out-of-range ones included.
- R6: `host_sel` 2 is routed by pointer bits 11:8. Page 1 selects the cursor colours and pages 2 and 3 select the external banks. Any other page ignores writes, reads 0 and leaves the pointer and index unchanged.
- R7: On page 1 a cursor write is accepted when pointer bits 7:0 are below 4, and a cursor read is accepted when they are below 2. The access uses entry `ptr[1:0]`, byte `idx`. An accepted access performs a triplet advance. A rejected access changes nothing and reads 0.
- R8: On pages 2 and 3, `ext_rd` or `ext_wr` is raised in the same cycle as the host strobe. `ext_space` is 0 for page 2 and 1 for page 3, and `ext_ptr`, `ext_idx` and `ext_wdata` carry the pointer low byte, the index and the host data. A read returns `ext_rdata`. The pointer then moves according to `ext_adv`: 01 performs a triplet advance, 10 clears the index and increments the pointer, and 00 or 11 leaves both unchanged.
- R9: Read data appears on `host_rdata` one cycle after the read strobe and holds until the next read. When `host_wr` and `host_rd` are both high, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Single-cycle read strobe |
| host_wr | input | 1 | Single-cycle write strobe |
| host_sel | input | 2 | Offset select (host offset bits 3:2) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| ext_rd | output | 1 | Read strobe to the external banks |
| ext_wr | output | 1 | Write strobe to the external banks |
| ext_space | output | 1 | 0 for the control bank, 1 for the window bank |
| ext_ptr | output | 8 | Pointer bits 7:0 |
| ext_idx | output | 2 | Component index |
| ext_wdata | output | 8 | Write data to the external banks |
| ext_rdata | input | 8 | Read data from the external banks |
| ext_adv | input | 2 | Advance request from the external banks |

## Verification
The bench builds the block with its default sizes: 528 palette entries, four writable cursor entries and two readable cursor entries. With these sizes the in-range and out-of-range palette edge at 0x20F/0x210 and the gap between cursor write and read acceptance at pointer values 2 and 3 are both reachable. The full 12-bit pointer wrap from 0xFFF to 0x000 is also reachable. Pointer loads are biased towards those edge values so that random traffic crosses them often.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int PTR_W = 12;
  localparam int DW    = 8;

  typedef logic [PTR_W-1:0] ptr_t;
  typedef logic [1:0]       idx_t;

  localparam logic [1:0] SEL_LO   = 2'd0;
  localparam logic [1:0] SEL_HI   = 2'd1;
  localparam logic [1:0] SEL_IND  = 2'd2;
  localparam logic [1:0] SEL_PAL  = 2'd3;

  localparam logic [1:0] ADV_TRIP = 2'b01;
  localparam logic [1:0] ADV_REG  = 2'b10;

  typedef struct packed {
    ptr_t ptr;
    idx_t idx;
  } cursor_t;

  // Step the component index; on leaving blue, move to the next entry.
  function automatic cursor_t trip_step(input cursor_t c);
    cursor_t n;
    if (c.idx >= 2'd2) begin
      n.idx = 2'd0;
      n.ptr = c.ptr + ptr_t'(1);
    end else begin
      n.idx = c.idx + 2'd1;
      n.ptr = c.ptr;
    end
    return n;
  endfunction

  // Entry/byte pair to flat byte offset.
  function automatic int unsigned flat_of(input int unsigned entry, input idx_t comp);
    return entry * 3 + int'(comp);
  endfunction
endpackage

// File: rtl/clut_ptr_unit.sv
module clut_ptr_unit
  import clut_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          clr_idx,
  input  logic [DW-1:0] ld_data,
  input  logic          adv_trip,
  input  logic          adv_reg,
  output ptr_t          ptr,
  output idx_t          idx
);
  cursor_t cur_q, stepped;

  assign stepped = trip_step(cur_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (ld_lo) begin
      cur_q.ptr[7:0] <= ld_data;
      cur_q.idx      <= '0;
    end else if (ld_hi) begin
      cur_q.ptr[PTR_W-1:8] <= ld_data[PTR_W-9:0];
      cur_q.idx            <= '0;
    end else if (clr_idx) begin
      cur_q.idx <= '0;
    end else if (adv_trip) begin
      cur_q <= stepped;
    end else if (adv_reg) begin
      cur_q.idx <= '0;
      cur_q.ptr <= cur_q.ptr + ptr_t'(1);
    end
  end

  assign ptr = cur_q.ptr;
  assign idx = cur_q.idx;
endmodule

// File: rtl/clut_triplet_store.sv
module clut_triplet_store
  import clut_pkg::*;
#(
  parameter int ENTRIES = 528,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int BYTES  = ENTRIES * 3,
  localparam int FW     = $clog2(BYTES)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] entry,
  input  idx_t          comp,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [BYTES];
  logic [FW-1:0] flat;
  logic          flat_ok;

  assign flat    = FW'(flat_of(int'(entry), comp));
  assign flat_ok = flat_of(int'(entry), comp) < BYTES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= '0;
    end else if (we && flat_ok) begin
      mem[flat] <= wdata;
    end
  end

  assign rdata = flat_ok ? mem[flat] : '0;
endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
  import clut_pkg::*;
#(
  parameter int PAL_ENTRIES    = 528,
  parameter int CUR_WR_ENTRIES = 4,
  parameter int CUR_RD_ENTRIES = 2,
  localparam int PAL_AW = $clog2(PAL_ENTRIES),
  localparam int CUR_AW = (CUR_WR_ENTRIES > 1) ? $clog2(CUR_WR_ENTRIES) : 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [1:0]    host_sel,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          ext_rd,
  output logic          ext_wr,
  output logic          ext_space,
  output logic [7:0]    ext_ptr,
  output logic [1:0]    ext_idx,
  output logic [7:0]    ext_wdata,
  input  logic [7:0]    ext_rdata,
  input  logic [1:0]    ext_adv
);
  localparam ptr_t PAL_LIM   = ptr_t'(PAL_ENTRIES);
  localparam ptr_t CUR_WLIM  = ptr_t'(CUR_WR_ENTRIES);
  localparam ptr_t CUR_RLIM  = ptr_t'(CUR_RD_ENTRIES);

  ptr_t ptr_q;
  idx_t idx_q;

  // Named events, visible to the checker.
  logic          rd_eff, acc;
  logic [3:0]    page;
  logic          hit_lo, hit_hi, hit_cur, hit_ext, hit_pal;
  logic          cur_ok, pal_ok;
  logic          cur_we, pal_we;
  logic          adv_trip, adv_reg;
  logic [DW-1:0] pal_rdata, cur_rdata, rd_mux;

  assign rd_eff  = host_rd & ~host_wr;
  assign acc     = host_rd | host_wr;
  assign page    = ptr_q[11:8];

  assign hit_lo  = acc && host_sel == SEL_LO;
  assign hit_hi  = acc && host_sel == SEL_HI;
  assign hit_pal = acc && host_sel == SEL_PAL;
  assign hit_cur = acc && host_sel == SEL_IND && page == 4'd1;
  assign hit_ext = acc && host_sel == SEL_IND && (page == 4'd2 || page == 4'd3);

  assign cur_ok  = host_wr ? (ptr_q[7:0] < CUR_WLIM[7:0]) : (ptr_q[7:0] < CUR_RLIM[7:0]);
  assign pal_ok  = ptr_q < PAL_LIM;

  assign cur_we  = hit_cur && cur_ok && host_wr;
  assign pal_we  = hit_pal && pal_ok && host_wr;

  assign adv_trip = hit_pal || (hit_cur && cur_ok) || (hit_ext && ext_adv == ADV_TRIP);
  assign adv_reg  = hit_ext && ext_adv == ADV_REG;

  clut_ptr_unit u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_lo    (hit_lo && host_wr),
    .ld_hi    (hit_hi && host_wr),
    .clr_idx  (hit_lo || hit_hi),
    .ld_data  (host_wdata),
    .adv_trip (adv_trip),
    .adv_reg  (adv_reg),
    .ptr      (ptr_q),
    .idx      (idx_q)
  );

  clut_triplet_store #(.ENTRIES(PAL_ENTRIES)) u_pal (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pal_we),
    .entry (ptr_q[PAL_AW-1:0]),
    .comp  (idx_q),
    .wdata (host_wdata),
    .rdata (pal_rdata)
  );

  clut_triplet_store #(.ENTRIES(CUR_WR_ENTRIES)) u_cur (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cur_we),
    .entry (ptr_q[CUR_AW-1:0]),
    .comp  (idx_q),
    .wdata (host_wdata),
    .rdata (cur_rdata)
  );

  assign ext_rd    = hit_ext && rd_eff;
  assign ext_wr    = hit_ext && host_wr;
  assign ext_space = page[0];
  assign ext_ptr   = ptr_q[7:0];
  assign ext_idx   = idx_q;
  assign ext_wdata = host_wdata;

  always_comb begin
    rd_mux = '0;
    unique case (host_sel)
      SEL_LO:  rd_mux = ptr_q[7:0];
      SEL_HI:  rd_mux = {4'd0, ptr_q[11:8]};
      SEL_IND: begin
        if (hit_cur && cur_ok) rd_mux = cur_rdata;
        else if (hit_ext)      rd_mux = ext_rdata;
      end
      SEL_PAL: if (pal_ok) rd_mux = pal_rdata;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      host_rdata <= '0;
    else if (rd_eff) host_rdata <= rd_mux;
  end
endmodule

// File: rtl/clut_host_port_chk.sv
module clut_host_port_chk #(
  parameter int PAL_ENTRIES = 528
)(
  input logic        clk,
  input logic        rst_n,
  input logic        host_rd,
  input logic        host_wr,
  input logic [1:0]  host_sel,
  input logic [7:0]  host_rdata,
  input logic        ext_rd,
  input logic        ext_wr,
  input logic [11:0] ptr,
  input logic [1:0]  idx,
  input logic        adv_trip,
  input logic        cur_hit,
  input logic        cur_ok
);
  localparam logic [11:0] LIM = 12'(PAL_ENTRIES);

  AST_IDX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    idx != 2'd3); // R3

  AST_PTRSEL_CLEARS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_rd || host_wr) && host_sel[1] == 1'b0) |=> idx == 2'd0); // R2

  AST_TRIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_trip && idx < 2'd2) |=> (idx == $past(idx) + 2'd1 && ptr == $past(ptr))); // R3

  AST_TRIP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_trip && idx == 2'd2) |=> (idx == 2'd0 && ptr == $past(ptr) + 12'd1)); // R3

  AST_PAL_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_rd || host_wr) && host_sel == 2'd3) |-> adv_trip); // R5

  AST_PAL_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_sel == 2'd3 && ptr >= LIM) |=> host_rdata == 8'd0); // R4

  AST_CUR_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_hit && !cur_ok) |=> ($stable(ptr) && $stable(idx))); // R7

  AST_EXT_ONLY_PAGES: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) |-> (host_sel == 2'd2 && (ptr[11:8] == 4'd2 || ptr[11:8] == 4'd3))); // R8

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && !host_wr) |=> $stable(host_rdata)); // R9
endmodule

bind clut_host_port clut_host_port_chk #(.PAL_ENTRIES(PAL_ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_sel   (host_sel),
  .host_rdata (host_rdata),
  .ext_rd     (ext_rd),
  .ext_wr     (ext_wr),
  .ptr        (ptr_q),
  .idx        (idx_q),
  .adv_trip   (adv_trip),
  .cur_hit    (hit_cur),
  .cur_ok     (cur_ok)
);

// File: tb/clut_host_port_test.sv
module clut_host_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       ext_rd, ext_wr, ext_space;
  logic [7:0] ext_ptr, ext_wdata, ext_rdata;
  logic [1:0] ext_idx, ext_adv;
  logic [1:0] adv_cfg = 2'b00;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] bank_byte(input logic sp, input logic [1:0] ix, input logic [7:0] p);
    return {sp, ix, p[4:0]} ^ 8'h5A;
  endfunction

  assign ext_rdata = bank_byte(ext_space, ext_idx, ext_ptr);
  assign ext_adv   = adv_cfg;

  clut_host_port uut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_space(ext_space), .ext_ptr(ext_ptr),
    .ext_idx(ext_idx), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_adv(ext_adv)
  );

  // Bench model
  logic [7:0]  m_pal [528*3];
  logic [7:0]  m_cur [12];
  logic [11:0] m_ptr = 12'd0;
  logic [1:0]  m_idx = 2'd0;
  logic [7:0]  m_last = 8'd0;
  string       tag_force = "";

  function automatic void m_step3();
    if (m_idx == 2'd2) begin m_idx = 2'd0; m_ptr = m_ptr + 12'd1; end
    else m_idx = m_idx + 2'd1;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic acc(input bit is_wr, input logic [1:0] sel, input logic [7:0] d, input logic [1:0] adv);
    logic [7:0] exp_v = 8'd0;
    bit er = 0, ew = 0;
    string tag;
    logic [3:0] pg = m_ptr[11:8];
    case (sel)
      2'd0: begin tag = "R2"; exp_v = m_ptr[7:0]; if (is_wr) m_ptr[7:0] = d; m_idx = 0; end
      2'd1: begin tag = "R2"; exp_v = {4'd0, m_ptr[11:8]}; if (is_wr) m_ptr[11:8] = d[3:0]; m_idx = 0; end
      2'd2: begin
        if (pg == 4'd1) begin
          tag = "R7";
          if (is_wr ? (m_ptr[7:0] < 8'd4) : (m_ptr[7:0] < 8'd2)) begin
            if (is_wr) m_cur[m_ptr[1:0]*3 + m_idx] = d;
            else exp_v = m_cur[m_ptr[1:0]*3 + m_idx];
            m_step3();
          end
        end else if (pg == 4'd2 || pg == 4'd3) begin
          tag = "R8"; er = !is_wr; ew = is_wr;
          exp_v = bank_byte(pg[0], m_idx, m_ptr[7:0]);
          if (adv == 2'b01) m_step3();
          else if (adv == 2'b10) begin m_idx = 0; m_ptr = m_ptr + 12'd1; end
        end else tag = "R6";
      end
      default: begin
        if (m_ptr < 12'd528) begin
          tag = "R4";
          if (is_wr) m_pal[m_ptr*3 + m_idx] = d; else exp_v = m_pal[m_ptr*3 + m_idx];
        end else tag = "R5";
        m_step3();
      end
    endcase
    if (tag_force != "") tag = tag_force;
    @(negedge clk);
    host_rd = !is_wr; host_wr = is_wr; host_sel = sel; host_wdata = d; adv_cfg = adv;
    #1;
    if (sel == 2'd2)
      check(ext_rd == er && ext_wr == ew, (er || ew) ? "R8" : tag, "ext strobes",
            {ext_rd, ext_wr}, {er, ew});
    @(negedge clk);
    host_rd = 0; host_wr = 0; adv_cfg = 2'b00;
    if (!is_wr) begin
      check(host_rdata == exp_v, tag, "read data", host_rdata, exp_v);
      m_last = exp_v;
    end else begin
      check(host_rdata == m_last, "R9", "rdata held over write", host_rdata, m_last);
    end
  endtask

  task automatic set_ptr(input logic [11:0] p);
    acc(1, 2'd0, p[7:0], 2'b00);
    acc(1, 2'd1, {4'd0, p[11:8]}, 2'b00);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] p;
    void'($urandom(32'd1234));
    for (int i = 0; i < 528*3; i++) m_pal[i] = 8'd0;
    for (int i = 0; i < 12; i++) m_cur[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(host_rdata == 8'd0, "R1", "rdata after reset", host_rdata, 0);
    tag_force = "R1";
    acc(0, 2'd0, 8'd0, 2'b00);
    acc(0, 2'd1, 8'd0, 2'b00);
    acc(0, 2'd3, 8'd0, 2'b00);
    set_ptr(12'h100);
    acc(0, 2'd2, 8'd0, 2'b00);
    // R3: wrap at the top of the pointer range
    tag_force = "R3";
    set_ptr(12'hFFF);
    for (int k = 0; k < 3; k++) acc(1, 2'd3, 8'hAA, 2'b00);
    acc(0, 2'd0, 8'd0, 2'b00);
    acc(0, 2'd1, 8'd0, 2'b00);
    // R4/R5: palette edge, 0x20F stored, 0x210 dropped
    tag_force = "";
    set_ptr(12'h20F);
    for (int k = 0; k < 6; k++) acc(1, 2'd3, 8'(8'h30 + k), 2'b00);
    set_ptr(12'h20F);
    for (int k = 0; k < 6; k++) acc(0, 2'd3, 8'd0, 2'b00);
    acc(0, 2'd0, 8'd0, 2'b00);
    // R7: cursor entry 3 writable, not readable
    set_ptr(12'h103);
    for (int k = 0; k < 3; k++) acc(1, 2'd2, 8'(8'hC0 + k), 2'b00);
    set_ptr(12'h103);
    acc(0, 2'd2, 8'd0, 2'b00);
    acc(0, 2'd0, 8'd0, 2'b00);
    // R6: unmapped page
    set_ptr(12'h5A0);
    acc(1, 2'd2, 8'h77, 2'b01);
    acc(0, 2'd2, 8'd0, 2'b01);
    acc(0, 2'd0, 8'd0, 2'b00);
    // R8: both advance codes on both banks
    set_ptr(12'h2FF);
    acc(0, 2'd2, 8'd0, 2'b10);
    acc(0, 2'd1, 8'd0, 2'b00);
    set_ptr(12'h305);
    acc(1, 2'd2, 8'h11, 2'b01);
    acc(0, 2'd2, 8'd0, 2'b11);
    acc(0, 2'd2, 8'd0, 2'b00);
    // Random traffic with biased pointer loads
    for (int n = 0; n < 3000; n++) begin
      int unsigned r = $urandom % 10;
      if (r < 2) begin
        logic [3:0] pg;
        logic [7:0] lo;
        case ($urandom % 7)
          0: pg = 4'd0; 1: pg = 4'd1; 2: pg = 4'd2; 3: pg = 4'd3;
          4: pg = 4'd4; 5: pg = 4'hF; default: pg = 4'($urandom);
        endcase
        case ($urandom % 8)
          0: lo = 8'd0; 1: lo = 8'd1; 2: lo = 8'd2; 3: lo = 8'd3;
          4: lo = 8'd4; 5: lo = 8'h0F; 6: lo = 8'h10; default: lo = 8'($urandom);
        endcase
        p = {pg, lo};
        set_ptr(p);
      end else begin
        acc(1'($urandom), (r < 6) ? 2'd2 : ((r < 9) ? 2'd3 : 2'($urandom)),
            8'($urandom), 2'($urandom));
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule